// File: doc/BRIEF.md
# Pixel Output Formatter

This block sits behind a digital video link receiver. It takes the decoded pixel stream and presents it on a parallel flat-panel interface. The core clock runs at twice the pixel rate, and a strobe marks the core cycle that carries each new pixel together with its data enable, horizontal sync, vertical sync and control bit. The block rebuilds the pixel timing on an output clock that it generates itself. That clock is a registered signal, so it has no combinational clock path.

Three static selects shape the panel side:
- **Pixels per output clock.** Either one pixel goes out on bus A, or pixels are packed in pairs onto bus A and bus B.
- **Latch edge.** Either the rising or the falling edge of the output clock is the edge the panel latches on. Outputs always change half an output-clock period away from that edge.
- **Output clock behaviour.** The output clock either runs all the time or is held low outside active video.

The selects are sampled only at the start of a vertical sync pulse, so a frame is never torn. An active-low disable input removes the drive enables of the panel-facing outputs. The link-status output and one spare control output keep driving, so the link-status output can be looped back onto the disable input.

Top module: `pxf_out_fmt`

## Requirements
- R1: Single mode. Every pixel that arrives with data enable high is presented exactly once on `pix_a_o`, in arrival order, at one latch edge each. The latch edges of an active run are 2 core cycles apart, and `pix_b_o` stays 0.
- R2: Paired mode. The first pixel after data enable rises goes on `pix_a_o` and the next one goes on `pix_b_o`, and so on in pairs. The latch edges of an active run are 4 core cycles apart.
- R3: Paired mode with an odd number of active pixels in a line. The last pixel is presented on `pix_a_o` with `pix_b_o` equal to 0.
- R4: With `latch_rise_i`=1 the latch edge is the 0-to-1 transition of `odck_o`; with 0 it is the 1-to-0 transition. `pix_a_o`, `pix_b_o`, `de_o`, `hs_o` and `vs_o` never change in the core cycle that produces the latch edge.
- R5: Free-running mode (`gate_low_i`=0). `odck_o` keeps toggling while `de_o` is low.
- R6: Gated mode (`gate_low_i`=1). `odck_o` is low whenever `de_o` is low. After a gap, the first latch edge comes only after the data for the line is already stable.
- R7: The three mode selects take effect only on a strobed cycle where `vs_i` has risen. Changing them at any other time has no effect. After reset the modes are: single, rising latch edge, free-running.
- R8: `oe_o` is all ones while `out_dis_n_i`=1 and all zeros while it is 0. The bits are: [0] both pixel buses, [1] `de_o`, [2] `hs_o`, [3] `vs_o`, [4] `ctl_o`, [5] `odck_o`.
- R9: `link_ok_o` and `ctl_keep_o` follow `link_i` and `ctl_keep_i` one core cycle later, whatever the value of `out_dis_n_i`. No bit of `oe_o` covers them.
- R10: During reset every data, sync, control and clock output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_stb_i | input | 1 | High on the core cycle carrying a new pixel; alternates with low |
| pix_i | input | PIX_W | Decoded pixel |
| de_i | input | 1 | Data enable of the pixel |
| hs_i | input | 1 | Horizontal sync of the pixel |
| vs_i | input | 1 | Vertical sync of the pixel |
| ctl_i | input | 1 | Control bit carried with the pixel |
| ctl_keep_i | input | 1 | Spare control bit that is never tri-stated |
| link_i | input | 1 | Link active flag |
| dual_mode_i | input | 1 | 1: two pixels per output clock |
| latch_rise_i | input | 1 | 1: panel latches on the rising edge of `odck_o` |
| gate_low_i | input | 1 | 1: output clock held low outside active video |
| out_dis_n_i | input | 1 | Active-low disable of the panel-facing outputs |
| pix_a_o | output | PIX_W | Pixel bus A (first or only pixel) |
| pix_b_o | output | PIX_W | Pixel bus B (second pixel of a pair) |
| de_o | output | 1 | Output data enable |
| hs_o | output | 1 | Output horizontal sync |
| vs_o | output | 1 | Output vertical sync |
| ctl_o | output | 1 | Output control bit |
| odck_o | output | 1 | Output pixel clock |
| oe_o | output | 6 | Drive enables of the tri-statable output groups |
| link_ok_o | output | 1 | Link status, always driven |
| ctl_keep_o | output | 1 | Spare control output, always driven |

## Verification
The assertions assume that `pix_stb_i` is never high on two core cycles in a row, and one assertion checks that contract. They also assume that mode selects only move the output clock while the registered modes are steady. For this reason the latch-edge and gating checks are qualified on the mode having been unchanged over the previous cycle.

The bench drives every pixel as one strobed cycle followed by one idle cycle. It changes the selects only well before a vertical sync pulse, or deliberately in mid-frame to show that they are ignored there. It keeps blanking intervals even in length, so the pairing of pixels always restarts on a pair boundary at the next line.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  // number of tri-statable output groups
  localparam int OE_W = 6;
  // width of the output clock phase counter
  localparam int PH_W = 2;

  typedef struct packed {
    logic dual;
    logic rise;
    logic gate;
  } pxf_mode_t;

  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
    logic ctl;
  } pxf_meta_t;

  localparam pxf_mode_t MODE_RESET = '{dual: 1'b0, rise: 1'b1, gate: 1'b0};
endpackage

// File: rtl/pxf_mode_latch.sv
module pxf_mode_latch
  import pxf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stb_i,
  input  logic      vs_i,
  input  logic      dual_i,
  input  logic      rise_i,
  input  logic      gate_i,
  output pxf_mode_t mode_o,
  output logic      apply_o
);
  logic      vs_prev_q, vs_prev_nxt;
  pxf_mode_t mode_q, mode_nxt;

  always_comb begin
    apply_o     = stb_i & vs_i & ~vs_prev_q;
    vs_prev_nxt = stb_i ? vs_i : vs_prev_q;
    mode_nxt    = mode_q;
    if (apply_o) begin
      mode_nxt.dual = dual_i;
      mode_nxt.rise = rise_i;
      mode_nxt.gate = gate_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_prev_q <= 1'b0;
      mode_q    <= MODE_RESET;
    end else begin
      vs_prev_q <= vs_prev_nxt;
      mode_q    <= mode_nxt;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pxf_pair_demux.sv
module pxf_pair_demux
  import pxf_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic             apply_i,
  input  logic             dual_i,
  input  logic [PIX_W-1:0] pix_i,
  input  pxf_meta_t        meta_i,
  output logic [PIX_W-1:0] pix_a_o,
  output logic [PIX_W-1:0] pix_b_o,
  output pxf_meta_t        meta_o,
  output logic             upd_o,
  output logic             de_nxt_o
);
  logic             first_q, first_nxt;
  logic             de_prev_q, de_prev_nxt;
  logic [PIX_W-1:0] hold_pix_q, hold_pix_nxt;
  pxf_meta_t        hold_meta_q, hold_meta_nxt;
  logic [PIX_W-1:0] a_q, a_nxt, b_q, b_nxt;
  pxf_meta_t        meta_q, meta_nxt;
  logic             de_rise, take_first;

  always_comb begin
    de_rise       = meta_i.de & ~de_prev_q;
    take_first    = dual_i & (de_rise | first_q);
    upd_o         = stb_i & ~take_first;
    de_prev_nxt   = stb_i ? meta_i.de : de_prev_q;
    hold_pix_nxt  = hold_pix_q;
    hold_meta_nxt = hold_meta_q;
    a_nxt         = a_q;
    b_nxt         = b_q;
    meta_nxt      = meta_q;
    first_nxt     = first_q;
    if (stb_i && take_first) begin
      hold_pix_nxt  = pix_i;
      hold_meta_nxt = meta_i;
    end
    if (upd_o) begin
      if (dual_i) begin
        a_nxt    = hold_pix_q;
        // partner of a line's last pixel is zero-filled
        b_nxt    = meta_i.de ? pix_i : '0;
        meta_nxt = hold_meta_q;
      end else begin
        a_nxt    = pix_i;
        b_nxt    = '0;
        meta_nxt = meta_i;
      end
    end
    if (stb_i && dual_i) first_nxt = ~take_first;
    if (apply_i)         first_nxt = 1'b1;
    de_nxt_o = meta_nxt.de;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q     <= 1'b1;
      de_prev_q   <= 1'b0;
      hold_pix_q  <= '0;
      hold_meta_q <= '0;
      a_q         <= '0;
      b_q         <= '0;
      meta_q      <= '0;
    end else begin
      first_q     <= first_nxt;
      de_prev_q   <= de_prev_nxt;
      hold_pix_q  <= hold_pix_nxt;
      hold_meta_q <= hold_meta_nxt;
      a_q         <= a_nxt;
      b_q         <= b_nxt;
      meta_q      <= meta_nxt;
    end
  end

  assign pix_a_o = a_q;
  assign pix_b_o = b_q;
  assign meta_o  = meta_q;
endmodule

// File: rtl/pxf_clk_gen.sv
module pxf_clk_gen
  import pxf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic dual_i,
  input  logic rise_i,
  input  logic gate_i,
  input  logic de_nxt_i,
  output logic odck_o
);
  localparam logic [PH_W-1:0] PH_MAX = '1;

  logic [PH_W-1:0] ph_q, ph_nxt, half;
  logic            odck_q, odck_nxt, lvl;

  always_comb begin
    // phase 0 is the data update; saturate so a late update stretches, never shortens
    if (upd_i)              ph_nxt = '0;
    else if (ph_q == PH_MAX) ph_nxt = ph_q;
    else                    ph_nxt = ph_q + 1'b1;
    half     = dual_i ? PH_W'(2) : PH_W'(1);
    lvl      = (ph_nxt >= half) ? rise_i : ~rise_i;
    odck_nxt = (gate_i && !de_nxt_i) ? 1'b0 : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      odck_q <= 1'b0;
    end else begin
      ph_q   <= ph_nxt;
      odck_q <= odck_nxt;
    end
  end

  assign odck_o = odck_q;
endmodule

// File: rtl/pxf_out_fmt.sv
module pxf_out_fmt
  import pxf_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_stb_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             de_i,
  input  logic             hs_i,
  input  logic             vs_i,
  input  logic             ctl_i,
  input  logic             ctl_keep_i,
  input  logic             link_i,
  input  logic             dual_mode_i,
  input  logic             latch_rise_i,
  input  logic             gate_low_i,
  input  logic             out_dis_n_i,
  output logic [PIX_W-1:0] pix_a_o,
  output logic [PIX_W-1:0] pix_b_o,
  output logic             de_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic             ctl_o,
  output logic             odck_o,
  output logic [OE_W-1:0]  oe_o,
  output logic             link_ok_o,
  output logic             ctl_keep_o
);
  logic      rst_meta_q, rst_core_q;
  pxf_mode_t mode_q;
  logic      apply, upd, de_nxt;
  pxf_meta_t meta_in, meta_out;
  logic      link_q, keep_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_q <= rst_meta_q;
    end
  end

  always_comb meta_in = '{de: de_i, hs: hs_i, vs: vs_i, ctl: ctl_i};

  pxf_mode_latch u_mode (
    .clk(clk), .rst_n(rst_core_q), .stb_i(pix_stb_i), .vs_i(vs_i),
    .dual_i(dual_mode_i), .rise_i(latch_rise_i), .gate_i(gate_low_i),
    .mode_o(mode_q), .apply_o(apply)
  );

  pxf_pair_demux #(.PIX_W(PIX_W)) u_demux (
    .clk(clk), .rst_n(rst_core_q), .stb_i(pix_stb_i), .apply_i(apply),
    .dual_i(mode_q.dual), .pix_i(pix_i), .meta_i(meta_in),
    .pix_a_o(pix_a_o), .pix_b_o(pix_b_o), .meta_o(meta_out),
    .upd_o(upd), .de_nxt_o(de_nxt)
  );

  pxf_clk_gen u_clk (
    .clk(clk), .rst_n(rst_core_q), .upd_i(upd), .dual_i(mode_q.dual),
    .rise_i(mode_q.rise), .gate_i(mode_q.gate), .de_nxt_i(de_nxt),
    .odck_o(odck_o)
  );

  always_comb begin
    de_o  = meta_out.de;
    hs_o  = meta_out.hs;
    vs_o  = meta_out.vs;
    ctl_o = meta_out.ctl;
    oe_o  = out_dis_n_i ? {OE_W{1'b1}} : {OE_W{1'b0}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      keep_q <= 1'b0;
    end else begin
      link_q <= link_i;
      keep_q <= ctl_keep_i;
    end
  end

  assign link_ok_o  = link_q;
  assign ctl_keep_o = keep_q;
endmodule

// File: rtl/pxf_out_fmt_chk.sv
module pxf_out_fmt_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_stb_i,
  input logic             vs_i,
  input logic             odck_o,
  input logic             de_o,
  input logic             hs_o,
  input logic [PIX_W-1:0] pix_a_o,
  input logic [PIX_W-1:0] pix_b_o,
  input logic             dual_q,
  input logic             rise_q,
  input logic             gate_q
);
  // input contract behind R1/R2: strobe never on two cycles running
  assert_stb_alt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb_i |=> !pix_stb_i);

  assert_gated_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && $past(gate_q) && !de_o) |-> !odck_o);

  assert_latch_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(odck_o) && rise_q && $past(rise_q) && (dual_q == $past(dual_q)))
      |-> ($stable(pix_a_o) && $stable(pix_b_o) && $stable(de_o) && $stable(hs_o)));

  assert_latch_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(odck_o) && !rise_q && !$past(rise_q) && (dual_q == $past(dual_q)))
      |-> ($stable(pix_a_o) && $stable(pix_b_o) && $stable(de_o) && $stable(hs_o)));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pix_stb_i && vs_i) |-> $stable({dual_q, rise_q, gate_q}));
endmodule

bind pxf_out_fmt pxf_out_fmt_chk #(.PIX_W(PIX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_stb_i(pix_stb_i), .vs_i(vs_i),
  .odck_o(odck_o), .de_o(de_o), .hs_o(hs_o), .pix_a_o(pix_a_o),
  .pix_b_o(pix_b_o), .dual_q(mode_q.dual), .rise_q(mode_q.rise),
  .gate_q(mode_q.gate)
);

// File: tb/pxf_out_fmt_tb_top.sv
`timescale 1ns/1ps
module pxf_out_fmt_tb_top;
  localparam int PW  = 8;
  localparam int OEW = pxf_pkg::OE_W;
  localparam logic [PW-1:0] BLANK_PIX = 8'hEE;

  logic clk, rst_n, pix_stb_i, de_i, hs_i, vs_i, ctl_i, ctl_keep_i, link_i;
  logic dual_mode_i, latch_rise_i, gate_low_i, out_dis_n_i;
  logic [PW-1:0] pix_i, pix_a_o, pix_b_o;
  logic de_o, hs_o, vs_o, ctl_o, odck_o, link_ok_o, ctl_keep_o;
  logic [OEW-1:0] oe_o;

  pxf_out_fmt #(.PIX_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_stb_i(pix_stb_i), .pix_i(pix_i),
    .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i), .ctl_i(ctl_i),
    .ctl_keep_i(ctl_keep_i), .link_i(link_i), .dual_mode_i(dual_mode_i),
    .latch_rise_i(latch_rise_i), .gate_low_i(gate_low_i),
    .out_dis_n_i(out_dis_n_i), .pix_a_o(pix_a_o), .pix_b_o(pix_b_o),
    .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o), .ctl_o(ctl_o), .odck_o(odck_o),
    .oe_o(oe_o), .link_ok_o(link_ok_o), .ctl_keep_o(ctl_keep_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor state
  bit mon_en = 0, cur_dual = 0, cur_rise = 1, cur_gate = 0;
  string cur_req = "R1";
  logic [PW-1:0] exp_pix [0:255];
  int exp_n = 0, cap_n = 0, cyc = 0, last_latch = -1;
  int gate_viol = 0, blank_tog = 0, per_err = 0, stab_err = 0, bnz = 0;
  logic p_odck = 0, p_de = 0, p_hs = 0, p_vs = 0;
  logic [PW-1:0] p_a = '0, p_b = '0;

  always @(negedge clk) begin
    bit latch;
    cyc++;
    latch = cur_rise ? (!p_odck && odck_o) : (p_odck && !odck_o);
    if (mon_en) begin
      if (cur_gate && !de_o && odck_o) gate_viol++;
      if (!de_o && (odck_o != p_odck)) blank_tog++;
      if (!cur_dual && pix_b_o != '0) bnz++;
      if (!de_o) last_latch = -1;
      if (latch) begin
        if (!(pix_a_o == p_a && pix_b_o == p_b && de_o == p_de &&
              hs_o == p_hs && vs_o == p_vs)) stab_err++;
        if (de_o) begin
          if (last_latch >= 0 && (cyc - last_latch) != (cur_dual ? 4 : 2)) per_err++;
          last_latch = cyc;
          chk(cap_n < exp_n && pix_a_o == exp_pix[cap_n], cur_req, int'(pix_a_o),
              cap_n < exp_n ? int'(exp_pix[cap_n]) : -1);
          cap_n++;
          if (cur_dual) begin
            chk(cap_n < exp_n && pix_b_o == exp_pix[cap_n], cur_req, int'(pix_b_o),
                cap_n < exp_n ? int'(exp_pix[cap_n]) : -1);
            cap_n++;
          end
        end
      end
    end
    p_odck = odck_o; p_de = de_o; p_hs = hs_o; p_vs = vs_o;
    p_a = pix_a_o;   p_b = pix_b_o;
  end

  task automatic drive(input logic [PW-1:0] v, input logic de, input logic hs, input logic vs);
    @(negedge clk);
    pix_i = v; de_i = de; hs_i = hs; vs_i = vs; ctl_i = de; pix_stb_i = 1'b1;
    @(negedge clk);
    pix_stb_i = 1'b0;
  endtask

  task automatic run_frame(input bit dv, input bit rs, input bit gt, input bit do_vs,
                           input int len, input int nl);
    mon_en = 0;
    dual_mode_i = dv; latch_rise_i = rs; gate_low_i = gt;
    if (do_vs) begin
      cur_dual = dv; cur_rise = rs; cur_gate = gt;
      for (int i = 0; i < 4; i++) drive(BLANK_PIX, 1'b0, 1'b0, 1'b1);
      // R7: selects flipped mid-frame must not take effect
      dual_mode_i = ~dv; latch_rise_i = ~rs; gate_low_i = ~gt;
      for (int i = 0; i < 4; i++) drive(BLANK_PIX, 1'b0, 1'b0, 1'b0);
    end else begin
      cur_dual = 0; cur_rise = 1; cur_gate = 0;
    end
    cur_req = !do_vs ? "R7" : (dv && (len % 2 == 1)) ? "R3" : dv ? "R2" : "R1";
    exp_n = 0; cap_n = 0; gate_viol = 0; blank_tog = 0; per_err = 0;
    stab_err = 0; bnz = 0; last_latch = -1;
    mon_en = 1;
    for (int l = 0; l < nl; l++) begin
      for (int c = 0; c < len; c++) begin
        exp_pix[exp_n] = PW'(l * len + c + 1); exp_n++;
        drive(PW'(l * len + c + 1), 1'b1, 1'b0, 1'b0);
      end
      if (cur_dual && (len % 2 == 1)) begin exp_pix[exp_n] = '0; exp_n++; end
      for (int b = 0; b < 6; b++) drive(BLANK_PIX, 1'b0, b < 2, 1'b0);
    end
    for (int i = 0; i < 4; i++) drive(BLANK_PIX, 1'b0, 1'b0, 1'b0);
    mon_en = 0;
    chk(cap_n == exp_n, cur_req, cap_n, exp_n);
    chk(per_err == 0, cur_dual ? "R2" : "R1", per_err, 0);
    chk(stab_err == 0, "R4", stab_err, 0);
    if (cur_gate) chk(gate_viol == 0, "R6", gate_viol, 0);
    else          chk(blank_tog > 0, "R5", blank_tog, 1);
    if (!cur_dual) chk(bnz == 0, do_vs ? "R1" : "R7", bnz, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pix_stb_i = 0; pix_i = '0; de_i = 0; hs_i = 0; vs_i = 0; ctl_i = 0;
    ctl_keep_i = 0; link_i = 0; dual_mode_i = 0; latch_rise_i = 1; gate_low_i = 0;
    out_dis_n_i = 1;
    repeat (4) @(negedge clk);
    // R10 reset values
    chk(pix_a_o == '0 && pix_b_o == '0, "R10", int'(pix_a_o), 0);
    chk({de_o, hs_o, vs_o, ctl_o, odck_o} == 5'b0, "R10",
        int'({de_o, hs_o, vs_o, ctl_o, odck_o}), 0);
    chk(oe_o == '1, "R8", int'(oe_o), (1 << OEW) - 1);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R8 / R9: disable spares the status and spare control outputs
    out_dis_n_i = 0; link_i = 1; ctl_keep_i = 1;
    @(negedge clk);
    chk(oe_o == '0, "R8", int'(oe_o), 0);
    chk(link_ok_o == 1'b1, "R9", link_ok_o, 1);
    chk(ctl_keep_o == 1'b1, "R9", ctl_keep_o, 1);
    link_i = 0;
    @(negedge clk);
    chk(link_ok_o == 1'b0, "R9", link_ok_o, 0);
    out_dis_n_i = 1;
    @(negedge clk);
    chk(oe_o == '1, "R8", int'(oe_o), (1 << OEW) - 1);
    link_i = 1;

    // R7: no vertical sync yet, selects ignored, reset modes in force
    run_frame(1'b1, 1'b0, 1'b1, 1'b0, 4, 2);

    // sweep all mode combinations with even and odd line lengths
    for (int m = 0; m < 8; m++) begin
      for (int ln = 4; ln <= 5; ln++) begin
        run_frame(m[0], m[1], m[2], 1'b1, ln, 3);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule